// File: doc/BRIEF.md
# Shared-Bus Enable Sampling Controller

This block decides whether a device may use a storage-side parallel bus that it shares with another bus master. An external enable pin, held by the other master, is synchronised and then looked at only on a slow periodic tick (about 60 times per second by default). The block compares each sample with the one before it and acts on the rising and falling edges it finds. From these edges it sets the bus output-enable, the host-link connect signal and a low-power request. When the link comes back it raises a one-cycle soft-reset pulse so that the device restarts from its post-reset state.

A configuration bit turns the whole mechanism on or off. When it is clear the bus stays driven and the link stays connected, whatever the pin does. The controller also takes a flag that reports suspend from other causes. While that flag is set, a sampled edge only opens a one-cycle wake window so the bus drive can be updated. The link then stays down until the other suspend cause clears.

Top module: `shbus_enable_ctrl`

## Requirements
- R1: While reset is asserted, and after it until the first sample, soft_rst_pulse, wake_req and lowpwr_req are 0. With cfg_gate at 1, bus_oe and link_connect are 0 in that interval. A reset clears a pending low-power request.
- R2: en_pin passes through two synchroniser flops and is sampled once every TICK_CYCLES clocks. The first sample after reset only loads the previous-sample state: it produces no soft_rst_pulse and no wake_req. With cfg_gate at 1, bus_oe and link_connect take that sample's level and lowpwr_req takes its inverse.
- R3: With cfg_gate at 0, bus_oe and link_connect are 1, lowpwr_req is 0, and neither pulse output is ever raised, whatever en_pin does.
- R4: With cfg_gate at 1 and ext_suspend at 0, a 1-to-0 change between two samples sets bus_oe to 0 (high impedance), link_connect to 0 and lowpwr_req to 1.
- R5: lowpwr_req stays at 1 for as long as the samples stay at 0.
- R6: With cfg_gate at 1 and ext_suspend at 0, a 0-to-1 change between samples does four things. It sets bus_oe to 1 and lowpwr_req to 0. It raises soft_rst_pulse for exactly one cycle. It sets link_connect to 1.
- R7: With cfg_gate at 1 and ext_suspend at 1, either sampled edge raises wake_req for exactly one cycle and updates bus_oe and lowpwr_req as in R4 or R6. It raises no soft_rst_pulse and leaves link_connect at 0.
- R8: When cfg_gate is 1, the last sample is 1, the link is down and ext_suspend is 0, the block raises one soft_rst_pulse and sets link_connect to 1. This completes a reconnect that was deferred by R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pin | input | 1 | Asynchronous enable from the other bus master; 1 lets this device use the bus |
| cfg_gate | input | 1 | Configuration bit; 1 lets a low enable release the bus |
| ext_suspend | input | 1 | Device already suspended for another reason |
| bus_oe | output | 1 | 1 drives the shared bus pins, 0 leaves them high impedance |
| link_connect | output | 1 | Host-link connect request |
| lowpwr_req | output | 1 | Low-power state request |
| soft_rst_pulse | output | 1 | One-cycle return to the post-reset operational state |
| wake_req | output | 1 | One-cycle wake window while suspended for another reason |

## Verification
A change on en_pin needs two clocks to cross the synchroniser. It is then seen at the next tick edge, which can come up to TICK_CYCLES clocks later. The sample register updates at that edge and the output state one edge after it. A reconnect and its soft_rst_pulse follow one further edge later. Each scenario therefore waits two full sample periods plus a few clocks before it reads the levels at a falling edge. Pulses are counted by a monitor throughout that window, which also flags any pulse longer than one cycle. In this way a check never depends on the tick phase.

// File: rtl/shbus_pkg.sv
package shbus_pkg;

    // Event produced by one periodic sample of the enable level
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_INIT = 2'd1,
        EV_RISE = 2'd2,
        EV_FALL = 2'd3
    } samp_ev_e;

    typedef struct packed {
        samp_ev_e ev;
        logic     level;
        logic     primed;
    } samp_s;

    typedef struct packed {
        logic bus_on;
        logic link_on;
        logic lowpwr;
    } drv_state_s;

    localparam drv_state_s DRV_RESET = '{bus_on: 1'b0, link_on: 1'b0, lowpwr: 1'b0};
    localparam samp_s      SAMP_RESET = '{ev: EV_NONE, level: 1'b0, primed: 1'b0};

    function automatic drv_state_s state_from_level(input logic lvl);
        drv_state_s r;
        r.bus_on  = lvl;
        r.link_on = lvl;
        r.lowpwr  = ~lvl;
        return r;
    endfunction

    function automatic samp_ev_e classify(input logic primed, input logic prev,
                                          input logic cur);
        if (!primed)            return EV_INIT;
        else if (!prev && cur)  return EV_RISE;
        else if (prev && !cur)  return EV_FALL;
        else                    return EV_NONE;
    endfunction

endpackage

// File: rtl/shbus_tick.sv
module shbus_tick #(
    parameter int unsigned TICK_CYCLES = 800_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt;

    initial assert (TICK_CYCLES >= 2) else $error("TICK_CYCLES must be at least 2");

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R2: samples are spaced, never on back-to-back cycles
    p_tick_spaced_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/shbus_sync.sv
module shbus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sh[0] <= 1'b0;
                    else     sh[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sh[i] <= 1'b0;
                    else     sh[i] <= sh[i-1];
                end
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/shbus_sampler.sv
module shbus_sampler
    import shbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  lvl,
    output samp_s samp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            samp <= SAMP_RESET;
        end else if (tick) begin
            samp.ev     <= classify(samp.primed, samp.level, lvl);
            samp.level  <= lvl;
            samp.primed <= 1'b1;
        end else begin
            samp.ev <= EV_NONE;
        end
    end

    // R2: an edge event agrees with the level it was taken from
    p_rise_level_r2: assert property (@(posedge clk) disable iff (rst)
        (samp.ev == EV_RISE) |-> samp.level);
    p_fall_level_r2: assert property (@(posedge clk) disable iff (rst)
        (samp.ev == EV_FALL) |-> !samp.level);
    // R2: an event lasts one cycle only
    p_event_single_r2: assert property (@(posedge clk) disable iff (rst)
        (samp.ev != EV_NONE) |=> (samp.ev == EV_NONE));
endmodule

// File: rtl/shbus_ctrl.sv
module shbus_ctrl
    import shbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  samp_s      samp,
    input  logic       cfg_gate,
    input  logic       ext_suspend,
    output drv_state_s st,
    output logic       soft_rst,
    output logic       wake
);
    logic relink;
    assign relink = cfg_gate && samp.primed && st.bus_on && !st.link_on && !ext_suspend;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= DRV_RESET;
            soft_rst <= 1'b0;
            wake     <= 1'b0;
        end else begin
            soft_rst <= 1'b0;
            wake     <= 1'b0;
            case (samp.ev)
                EV_INIT: st <= state_from_level(samp.level);
                EV_FALL: begin
                    st.bus_on  <= 1'b0;
                    st.link_on <= 1'b0;
                    st.lowpwr  <= 1'b1;
                    if (cfg_gate && ext_suspend) wake <= 1'b1;
                end
                EV_RISE: begin
                    st.bus_on <= 1'b1;
                    st.lowpwr <= 1'b0;
                    if (cfg_gate && ext_suspend) wake <= 1'b1;
                end
                default: begin
                    if (relink) begin
                        st.link_on <= 1'b1;
                        soft_rst   <= 1'b1;
                    end
                end
            endcase
        end
    end

    // R6: the soft reset is a single-cycle pulse
    p_soft_single_r6: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !soft_rst);
    // R7: the wake window is a single cycle
    p_wake_single_r7: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);
    // R8: a reconnect only follows a sample at level 1
    p_relink_level_r8: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> samp.level);
endmodule

// File: rtl/shbus_enable_ctrl.sv
module shbus_enable_ctrl
    import shbus_pkg::*;
#(
    parameter int unsigned TICK_CYCLES = 800_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en_pin,
    input  logic cfg_gate,
    input  logic ext_suspend,
    output logic bus_oe,
    output logic link_connect,
    output logic lowpwr_req,
    output logic soft_rst_pulse,
    output logic wake_req
);
    logic       en_sync;
    logic       tick;
    samp_s      samp;
    drv_state_s st;

    shbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (en_pin),
        .q   (en_sync)
    );

    shbus_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    shbus_sampler u_samp (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .lvl  (en_sync),
        .samp (samp)
    );

    shbus_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .samp        (samp),
        .cfg_gate    (cfg_gate),
        .ext_suspend (ext_suspend),
        .st          (st),
        .soft_rst    (soft_rst_pulse),
        .wake        (wake_req)
    );

    // Configuration gate masks the whole release mechanism
    assign bus_oe       = !cfg_gate || st.bus_on;
    assign link_connect = !cfg_gate || st.link_on;
    assign lowpwr_req   = cfg_gate && st.lowpwr;

    // R4: low power never coexists with a driven bus
    p_lowpwr_hiz_r4: assert property (@(posedge clk) disable iff (rst)
        lowpwr_req |-> !bus_oe);
    // R6: the link is only up while the bus is driven
    p_link_needs_bus_r6: assert property (@(posedge clk) disable iff (rst)
        link_connect |-> bus_oe);
    // R3: gate clear means no pulses on the next cycle
    p_gate_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_gate |=> (!soft_rst_pulse && !wake_req));
    // R7: no soft reset while another suspend cause was active
    p_susp_no_reset_r7: assert property (@(posedge clk) disable iff (rst)
        soft_rst_pulse |-> !$past(ext_suspend));
endmodule

// File: tb/shbus_enable_ctrl_tb.sv
module shbus_enable_ctrl_tb;
    localparam int unsigned TICK = 16;
    localparam int unsigned SETTLE = 2 * TICK + 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_pin = 1'b1;
    logic cfg_gate = 1'b1;
    logic ext_suspend = 1'b0;
    logic bus_oe, link_connect, lowpwr_req, soft_rst_pulse, wake_req;

    int n_chk = 0;
    int n_fail = 0;
    int n_soft = 0;
    int n_wake = 0;
    logic wide = 1'b0;
    logic prev_soft = 1'b0;
    logic prev_wake = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    shbus_enable_ctrl #(.TICK_CYCLES(TICK)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .en_pin         (en_pin),
        .cfg_gate       (cfg_gate),
        .ext_suspend    (ext_suspend),
        .bus_oe         (bus_oe),
        .link_connect   (link_connect),
        .lowpwr_req     (lowpwr_req),
        .soft_rst_pulse (soft_rst_pulse),
        .wake_req       (wake_req)
    );

    always @(posedge clk) begin
        if (soft_rst_pulse) n_soft++;
        if (wake_req) n_wake++;
        if ((soft_rst_pulse && prev_soft) || (wake_req && prev_wake)) wide = 1'b1;
        prev_soft = soft_rst_pulse;
        prev_wake = wake_req;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clr();
        @(negedge clk);
        n_soft = 0;
        n_wake = 0;
    endtask

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_soft = 0;
        n_wake = 0;
    endtask

    // R1: state before the first sample
    task automatic t_reset();
        do_reset();
        repeat (2) @(negedge clk);
        check("R1", "bus_oe", bus_oe, 0);
        check("R1", "link_connect", link_connect, 0);
        check("R1", "lowpwr_req", lowpwr_req, 0);
        check("R1", "pulses", n_soft + n_wake, 0);
    endtask

    // R2: first sample loads the level without an edge
    task automatic t_first();
        settle();
        check("R2", "bus_oe", bus_oe, 1);
        check("R2", "link_connect", link_connect, 1);
        check("R2", "lowpwr_req", lowpwr_req, 0);
        check("R2", "soft pulses", n_soft, 0);
    endtask

    // R4 and R5: falling edge and hold
    task automatic t_fall();
        clr();
        en_pin = 1'b0;
        settle();
        check("R4", "bus_oe", bus_oe, 0);
        check("R4", "link_connect", link_connect, 0);
        check("R4", "lowpwr_req", lowpwr_req, 1);
        repeat (5 * TICK) @(posedge clk);
        @(negedge clk);
        check("R5", "lowpwr_req held", lowpwr_req, 1);
        check("R5", "pulses", n_soft + n_wake, 0);
    endtask

    // R6: rising edge with no other suspend cause
    task automatic t_rise();
        clr();
        en_pin = 1'b1;
        settle();
        check("R6", "soft pulses", n_soft, 1);
        check("R6", "wake pulses", n_wake, 0);
        check("R6", "bus_oe", bus_oe, 1);
        check("R6", "link_connect", link_connect, 1);
        check("R6", "lowpwr_req", lowpwr_req, 0);
    endtask

    // R7 and R8: edges while suspended, then deferred reconnect
    task automatic t_susp();
        clr();
        ext_suspend = 1'b1;
        en_pin = 1'b0;
        settle();
        check("R7", "wake after fall", n_wake, 1);
        check("R7", "bus_oe after fall", bus_oe, 0);
        check("R7", "lowpwr after fall", lowpwr_req, 1);
        en_pin = 1'b1;
        settle();
        check("R7", "wake after rise", n_wake, 2);
        check("R7", "soft pulses", n_soft, 0);
        check("R7", "bus_oe after rise", bus_oe, 1);
        check("R7", "link_connect", link_connect, 0);
        check("R7", "lowpwr after rise", lowpwr_req, 0);
        ext_suspend = 1'b0;
        repeat (4) @(negedge clk);
        check("R8", "soft pulses", n_soft, 1);
        check("R8", "link_connect", link_connect, 1);
    endtask

    // R3: gate clear ignores the pin
    task automatic t_gate();
        clr();
        cfg_gate = 1'b0;
        en_pin = 1'b0;
        settle();
        check("R3", "bus_oe", bus_oe, 1);
        check("R3", "link_connect", link_connect, 1);
        check("R3", "lowpwr_req", lowpwr_req, 0);
        en_pin = 1'b1;
        settle();
        check("R3", "pulses", n_soft + n_wake, 0);
        check("R3", "bus_oe after rise", bus_oe, 1);
    endtask

    // R1 and R2: reset clears low power, first sample at 0 gives no pulse
    task automatic t_reset_lowpwr();
        cfg_gate = 1'b1;
        en_pin = 1'b0;
        settle();
        check("R4", "lowpwr before reset", lowpwr_req, 1);
        ext_suspend = 1'b1;
        do_reset();
        @(negedge clk);
        check("R1", "lowpwr cleared", lowpwr_req, 0);
        check("R1", "bus_oe after reset", bus_oe, 0);
        settle();
        check("R2", "lowpwr from first sample", lowpwr_req, 1);
        check("R2", "no wake on first sample", n_wake, 0);
        check("R2", "bus_oe", bus_oe, 0);
    endtask

    initial begin
        t_reset();
        t_first();
        t_fall();
        t_rise();
        t_susp();
        t_gate();
        t_reset_lowpwr();
        check("R6", "pulse width one cycle", int'(wide), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule